// File: doc/BRIEF.md
# LCD Frame and Blink Timing Generator

This block produces all display timing for a multiplexed LCD driver from a single clock-enable, `tick_i`, that pulses at the nominal 32 kHz system rate. One divider chain, stepped by that tick, makes two outputs. The first is a common-slot advance strobe, whose period is set by the chosen frame rate and the number of common slots per frame. The second is a whole-display blank flag that follows a programmable blink rate. A slot sequencer counts strobes into frames. It marks each frame start and toggles a frame-parity bit, which the drive stage uses to invert polarity so the panel never sees DC.

Two control bits set the run state. The run bit starts or stops the oscillator; when it is clear, every counter is cleared and no strobe is issued. The display bit decides whether segments may show. The frame-rate bit picks the base rate or double the base rate. The duty bit picks 4 or 8 common slots. A 2-bit code picks blinking off or one of three blink periods.

Top module: `lcd_frame_timer`

## Requirements
- R1: While `rst_ni` is low and afterwards until the run bit is set, `slot_stb_o`, `frame_stb_o` and `frame_par_o` are 0 and `blank_o` is 1.
- R2: The slot strobe period, in ticks, is round(FSYS_HZ / (rate × slots)). The rate is FRAME_HZ when `fast_frame_i`=0 and 2×FRAME_HZ when it is 1. The slot count is 4 when `duty8_i`=0 and 8 when it is 1. With the defaults the four ratios are 102 (0,0), 51 (0,1), 51 (1,0) and 26 (1,1).
- R3: `frame_stb_o` is a one-cycle pulse that coincides with every 4th or 8th `slot_stb_o`, according to `duty8_i`.
- R4: `frame_par_o` changes in exactly the cycle in which `frame_stb_o` is high, and it holds at all other times while running.
- R5: Counters advance only in cycles where `tick_i` is high. With a tick every N clocks, the strobe period is N times the R2 ratio in clocks.
- R6: With `osc_en_i`=0, all counters and `frame_par_o` are cleared and no strobe is issued from the next cycle on. After the run bit is set again, the first slot strobe comes exactly one ratio of ticks later.
- R7: `blink_i` code 00 disables blinking. Codes 01, 10 and 11 give a full blink period of 16384, 32768 and 65536 ticks. `blank_o` is 0 in the first half of each period and 1 in the second half, counted from the start of running.
- R8: `blank_o` is 1 whenever `osc_en_i` or `disp_en_i` is 0.
- R9: When the ratio is changed to a value at or below the current count, the slot strobe follows at the very next tick.
- R10: With `osc_en_i`=1 and `disp_en_i`=0, slot and frame strobes keep running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Clock-enable at the system oscillator rate |
| osc_en_i | input | 1 | Run bit: 1 runs the oscillator and counters |
| disp_en_i | input | 1 | Display bit: 1 lets segments show |
| fast_frame_i | input | 1 | 0 selects the base frame rate, 1 doubles it |
| duty8_i | input | 1 | 0 selects 4 common slots, 1 selects 8 |
| blink_i | input | 2 | Blink code: 00 off, 01/10/11 period 16384/32768/65536 ticks |
| slot_stb_o | output | 1 | One-cycle common-slot advance strobe |
| frame_stb_o | output | 1 | One-cycle frame-start strobe |
| frame_par_o | output | 1 | Frame parity for polarity inversion |
| blank_o | output | 1 | Whole display blanked now |

## Verification
The bench measures the slot period for all four rate/duty settings, including the rounding case of 25.6 up to 26. A divider that truncated, or that counted one tick too many, would be off by one in that measure. It checks the first-strobe latency after a restart: a block that does not clear its counts when stopped would strobe early. It also switches from the longest ratio to the shortest partway through a count; an equality-only wrap would then run on until the counter wraps around. Blink edges are probed one tick before and at each half-period for every code, so a wrong tap bit or an inverted phase shows up as a misplaced edge. Frame tests count the slots per frame and the parity alternation, so a miscounted frame or a parity bit that drifts between frames is caught.

// File: rtl/lcd_timing_pkg.sv
package lcd_timing_pkg;

  typedef enum logic [1:0] {
    BLINK_OFF  = 2'b00,
    BLINK_FAST = 2'b01,
    BLINK_MID  = 2'b10,
    BLINK_SLOW = 2'b11
  } blink_code_e;

  // nearest-integer division
  function automatic int unsigned round_div(input int unsigned num,
                                            input int unsigned den);
    return (2 * num + den) / (2 * den);
  endfunction

endpackage

// File: rtl/slot_divider.sv
module slot_divider #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] ratio_i,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] top_w;

  assign top_w  = ratio_i - 1'b1;
  // >= so that a shrinking ratio wraps at the next tick
  assign wrap_o = run_i && tick_i && (cnt_q >= top_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!run_i)     cnt_q <= '0;
    else if (wrap_o)     cnt_q <= '0;
    else if (tick_i)     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer #(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             step_i,
  input  logic [IDX_W-1:0] last_i,
  output logic             slot_stb_o,
  output logic             frame_stb_o,
  output logic             frame_par_o
);
  logic [IDX_W-1:0] idx_q;
  logic             slot_q, frame_q, par_q;
  logic             last_hit;

  assign last_hit = idx_q >= last_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      slot_q  <= 1'b0;
      frame_q <= 1'b0;
      par_q   <= 1'b0;
    end else if (!run_i) begin
      idx_q   <= '0;
      slot_q  <= 1'b0;
      frame_q <= 1'b0;
      par_q   <= 1'b0;
    end else begin
      slot_q  <= step_i;
      frame_q <= step_i && last_hit;
      if (step_i) begin
        if (last_hit) begin
          idx_q <= '0;
          par_q <= ~par_q;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign slot_stb_o  = slot_q;
  assign frame_stb_o = frame_q;
  assign frame_par_o = par_q;
endmodule

// File: rtl/blink_divider.sv
module blink_divider
  import lcd_timing_pkg::*;
#(
  parameter int unsigned BLINK_LOG2 = 14
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        run_i,
  input  logic        tick_i,
  input  logic        disp_en_i,
  input  blink_code_e code_i,
  output logic        blank_o
);
  localparam int unsigned CNT_W = BLINK_LOG2 + 2;

  logic [CNT_W-1:0] cnt_q;
  logic [3:0]       tap_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!run_i)   cnt_q <= '0;
    else if (tick_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign tap_w[0] = 1'b0;
  for (genvar k = 1; k < 4; k++) begin : g_tap
    // code k: full period 2^(BLINK_LOG2+k-1), off in upper half
    assign tap_w[k] = cnt_q[BLINK_LOG2 - 2 + k];
  end

  assign blank_o = !(run_i && disp_en_i) || tap_w[code_i];
endmodule

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer
  import lcd_timing_pkg::*;
#(
  parameter int unsigned FSYS_HZ    = 32768,
  parameter int unsigned FRAME_HZ   = 80,
  parameter int unsigned SLOTS_LO   = 4,
  parameter int unsigned SLOTS_HI   = 8,
  parameter int unsigned BLINK_LOG2 = 14
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       osc_en_i,
  input  logic       disp_en_i,
  input  logic       fast_frame_i,
  input  logic       duty8_i,
  input  logic [1:0] blink_i,
  output logic       slot_stb_o,
  output logic       frame_stb_o,
  output logic       frame_par_o,
  output logic       blank_o
);
  localparam int unsigned DIV_S4 = round_div(FSYS_HZ, FRAME_HZ * SLOTS_LO);
  localparam int unsigned DIV_S8 = round_div(FSYS_HZ, FRAME_HZ * SLOTS_HI);
  localparam int unsigned DIV_F4 = round_div(FSYS_HZ, 2 * FRAME_HZ * SLOTS_LO);
  localparam int unsigned DIV_F8 = round_div(FSYS_HZ, 2 * FRAME_HZ * SLOTS_HI);
  localparam int unsigned CNT_W  = $clog2(DIV_S4 + 1);
  localparam int unsigned IDX_W  = $clog2(SLOTS_HI);

  logic [CNT_W-1:0] ratio_w;
  logic [IDX_W-1:0] last_w;
  logic             wrap_w;

  always_comb begin
    unique case ({fast_frame_i, duty8_i})
      2'b00:   ratio_w = CNT_W'(DIV_S4);
      2'b01:   ratio_w = CNT_W'(DIV_S8);
      2'b10:   ratio_w = CNT_W'(DIV_F4);
      default: ratio_w = CNT_W'(DIV_F8);
    endcase
  end

  assign last_w = duty8_i ? IDX_W'(SLOTS_HI - 1) : IDX_W'(SLOTS_LO - 1);

  slot_divider #(.CNT_W(CNT_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (osc_en_i),
    .tick_i (tick_i),
    .ratio_i(ratio_w),
    .wrap_o (wrap_w)
  );

  frame_sequencer #(.IDX_W(IDX_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (osc_en_i),
    .step_i     (wrap_w),
    .last_i     (last_w),
    .slot_stb_o (slot_stb_o),
    .frame_stb_o(frame_stb_o),
    .frame_par_o(frame_par_o)
  );

  blink_divider #(.BLINK_LOG2(BLINK_LOG2)) u_blink (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (osc_en_i),
    .tick_i   (tick_i),
    .disp_en_i(disp_en_i),
    .code_i   (blink_code_e'(blink_i)),
    .blank_o  (blank_o)
  );
endmodule

// File: rtl/lcd_frame_timer_checker.sv
module lcd_frame_timer_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic osc_en_i,
  input logic disp_en_i,
  input logic slot_stb_o,
  input logic frame_stb_o,
  input logic frame_par_o,
  input logic blank_o
);
  p_frame_in_slot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_stb_o |-> slot_stb_o);

  p_par_toggle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_stb_o |-> (frame_par_o != $past(frame_par_o)));

  p_par_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_stb_o && $past(osc_en_i)) |-> $stable(frame_par_o));

  p_tick_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_stb_o |-> $past(tick_i));

  p_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_i |=> (!slot_stb_o && !frame_stb_o && !frame_par_o));

  p_blank_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(osc_en_i && disp_en_i) |-> blank_o);
endmodule

bind lcd_frame_timer lcd_frame_timer_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .osc_en_i   (osc_en_i),
  .disp_en_i  (disp_en_i),
  .slot_stb_o (slot_stb_o),
  .frame_stb_o(frame_stb_o),
  .frame_par_o(frame_par_o),
  .blank_o    (blank_o)
);

// File: tb/lcd_frame_timer_bench.sv
module lcd_frame_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       osc_en = 1'b0, disp_en = 1'b0, fast = 1'b0, duty8 = 1'b0;
  logic [1:0] blink = 2'b00;
  logic       slot, frame, par, blank;

  int checks = 0, errors = 0, cyc = 0, tick_div = 1, tph = 0;

  always #10 clk = ~clk;

  lcd_frame_timer u_lcd_frame_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .osc_en_i(osc_en),
    .disp_en_i(disp_en), .fast_frame_i(fast), .duty8_i(duty8),
    .blink_i(blink), .slot_stb_o(slot), .frame_stb_o(frame),
    .frame_par_o(par), .blank_o(blank)
  );

  always @(negedge clk) begin
    tph  = (tph + 1) % tick_div;
    tick = (tph == 0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int exp_div(int rate, int slots);
    return ((32768 * 10 / (rate * slots)) + 5) / 10;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_slot();
    do @(negedge clk); while (!slot);
  endtask

  task automatic wait_frame();
    do @(negedge clk); while (!frame);
  endtask

  task automatic slot_period(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!slot);
  endtask

  // from a sampled frame strobe to the next: cycles, slot strobes, parity drift
  task automatic frame_period(output int n, output int s, output int drift, output int frame_no_slot);
    logic p0;
    p0 = par; n = 0; s = 0; drift = 0; frame_no_slot = 0;
    do begin
      @(negedge clk); n++;
      if (slot) s++;
      if (frame && !slot) frame_no_slot++;
      if (!frame && par != p0) drift++;
    end while (!frame);
  endtask

  task automatic restart();
    @(negedge clk); osc_en = 1'b0;
    repeat (3) @(negedge clk);
    osc_en = 1'b1;
  endtask

  task automatic blink_probe(logic [1:0] code, int half, string req);
    int n;
    @(negedge clk); osc_en = 1'b0; blink = code; disp_en = 1'b1;
    @(negedge clk); osc_en = 1'b1; n = 0;
    while (n < half - 1) begin @(negedge clk); n++; end
    chk(req, blank, 0);
    @(negedge clk); n++;
    chk(req, blank, (code == 2'b00) ? 0 : 1);
    if (code != 2'b00 && half <= 16384) begin
      while (n < 2 * half - 1) begin @(negedge clk); n++; end
      chk(req, blank, 1);
      @(negedge clk);
      chk(req, blank, 0);
    end
  endtask

  initial begin
    int n, s, d, f;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 slot", slot, 0); chk("R1 frame", frame, 0);
    chk("R1 par", par, 0);   chk("R1 blank", blank, 1);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R1 idle slot", slot, 0); chk("R1 idle blank", blank, 1);

    // R6 first strobe latency after start
    disp_en = 1'b1; osc_en = 1'b1;
    slot_period(n);
    chk("R6 first strobe", n, exp_div(80, 4));

    // R2 all four ratios
    for (int c = 0; c < 4; c++) begin
      fast = c[1]; duty8 = c[0];
      wait_slot(); wait_slot();
      slot_period(n);
      chk("R2 ratio", n, exp_div(fast ? 160 : 80, duty8 ? 8 : 4));
    end

    // R3 / R4 frames in both duties
    for (int c = 0; c < 2; c++) begin
      fast = 1'b0; duty8 = c[0];
      wait_frame(); wait_frame();
      for (int k = 0; k < 2; k++) begin
        logic p0;
        p0 = par;
        frame_period(n, s, d, f);
        chk("R3 frame period", n, (duty8 ? 8 : 4) * exp_div(80, duty8 ? 8 : 4));
        chk("R3 slots per frame", s, duty8 ? 8 : 4);
        chk("R3 frame without slot", f, 0);
        chk("R4 parity toggle", par, !p0);
        chk("R4 parity hold", d, 0);
      end
    end

    // R5 tick gating
    duty8 = 1'b0; tick_div = 3;
    wait_slot(); wait_slot();
    slot_period(n);
    chk("R5 gated period", n, 3 * exp_div(80, 4));
    tick_div = 1;

    // R6 stop: no strobes, parity cleared, exact restart
    @(negedge clk); osc_en = 1'b0;
    n = 0;
    for (int k = 0; k < 500; k++) begin @(negedge clk); if (slot || frame) n++; end
    chk("R6 no strobe when stopped", n, 0);
    chk("R6 parity cleared", par, 0);
    chk("R8 blank when stopped", blank, 1);
    osc_en = 1'b1;
    slot_period(n);
    chk("R6 restart latency", n, exp_div(80, 4));

    // R10 / R8 display off keeps timing running
    disp_en = 1'b0;
    wait_slot();
    slot_period(n);
    chk("R10 strobes with display off", n, exp_div(80, 4));
    chk("R8 blank with display off", blank, 1);
    disp_en = 1'b1;

    // R9 shrink ratio below current count
    wait_slot();
    repeat (60) @(negedge clk);
    chk("R9 no early strobe", slot, 0);
    fast = 1'b1; duty8 = 1'b1;
    @(negedge clk);
    chk("R9 immediate wrap", slot, 1);
    slot_period(n);
    chk("R9 new ratio", n, exp_div(160, 8));
    fast = 1'b0; duty8 = 1'b0;

    // R7 blink codes
    blink_probe(2'b00, 8192,  "R7 code00");
    blink_probe(2'b01, 8192,  "R7 code01");
    blink_probe(2'b10, 16384, "R7 code10");
    blink_probe(2'b11, 32768, "R7 code11");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule